// File: doc/BRIEF.md
# AC97 Stream Channel FIFO Controller

This block is the control and data path for one audio stream channel of an AC97 controller. A host reaches it over a simple single-cycle register bus. It holds a transmit control register and a receive control register. Each one enables its direction, chooses which of the two PCM slots (slot 3 and slot 4) carry samples, and chooses between compact packing, with two 16-bit samples in one 32-bit word, and one-sample-per-word packing. A status register reports whether the transmit FIFO is empty and whether it has run dry. Software can therefore drain the FIFO before it turns the stream off.

Both directions share one data register. A write pushes into the transmit FIFO and a read pops from the receive FIFO. For each frame, a frame serializer asks the block for the slot 3 and slot 4 samples to transmit. The serializer also hands in the samples it received. The block fills or drains the FIFOs according to the slot enables and the packing mode.

Several channels share one address space. Each channel instance answers only within its own 32-byte bank, which `CHAN_IDX` selects.

Top module: `ac_chan_ctl`

## Requirements
- R1: After reset, both control registers read 0, the status register reads 0x2 (transmit FIFO empty, no underrun), and `tx_slot_vld_o` is 0.
- R2: The channel decodes only byte addresses in the bank at (CHAN_IDX-1)*0x20. Within the bank the offsets are: data 0x0, receive control 0x4, transmit control 0x8, status 0xC. Reads of any other address return 0, and writes to any other address have no effect.
- R3: Both control registers use the same fields: bit 0 enables the direction, bit 3 enables slot 3, bit 4 enables slot 4, and bit 15 selects compact mode. A read returns only these bits and all other bits as 0.
- R4: In compact transmit mode, each data write is one FIFO entry. On the cycle after a frame request, the block presents bits 15:0 of the entry on slot 3 and bits 31:16 on slot 4. `tx_slot_vld_o` bit 0 marks slot 3 as valid and bit 1 marks slot 4. A disabled slot carries 0 with its valid bit clear.
- R5: In one-sample transmit mode, each data write supplies one sample in bits 15:0. A frame consumes one entry per enabled slot, with slot 3 filled before slot 4.
- R6: An underrun occurs when transmit is enabled with at least one slot enabled, a frame request arrives, and the FIFO holds fewer entries than the frame needs. On an underrun, the block sets status bit 6, sends 0 on the enabled slots with their valid bits set, and consumes no entry. Bit 6 stays set while the direction remains enabled.
- R7: Status bit 1 is 1 exactly when the transmit FIFO holds no entries.
- R8: Writing a control register with bit 0 clear flushes that direction's FIFO. On the transmit side this write also clears status bit 6. Data writes made while transmit is disabled are dropped.
- R9: Each FIFO holds FIFO_DEPTH (8) entries. A data write to a full transmit FIFO is dropped.
- R10: In compact receive mode, a received frame pushes one entry {slot 4, slot 3}, with 0 in the field of any disabled slot. A read of the data register pops and returns the oldest entry. A read of an empty receive FIFO returns 0.
- R11: In one-sample receive mode, each enabled slot pushes its own zero-extended entry, slot 3 first. A frame whose entries do not all fit is dropped whole.
- R12: While transmit is disabled, frame requests produce `tx_slot_vld_o` = 0 and never set the underrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 2*SAMPLE_W | Write data |
| bus_rdata_o | output | 2*SAMPLE_W | Read data, valid in the same cycle as the read strobe |
| tx_frame_req_i | input | 1 | Serializer requests the samples for the next frame |
| tx_slot_vld_o | output | 2 | Slot valid bits, bit 0 = slot 3, bit 1 = slot 4, one cycle after the request |
| tx_slot3_o | output | SAMPLE_W | Transmit sample for slot 3 |
| tx_slot4_o | output | SAMPLE_W | Transmit sample for slot 4 |
| rx_frame_vld_i | input | 1 | Serializer delivers one received frame |
| rx_slot3_i | input | SAMPLE_W | Received slot 3 sample |
| rx_slot4_i | input | SAMPLE_W | Received slot 4 sample |

## Verification
The bench builds the block with CHAN_IDX=2, so the bank sits at 0x20. This placement lets accesses to bank 0 act as the traffic of a neighbouring channel, and it exposes a decode that ignores the bank bits. FIFO_DEPTH stays at 8, so nine writes reach the full-FIFO drop and seven receive entries reach the partial-fit case, in which a two-sample frame must be dropped whole. SAMPLE_W=16 keeps the compact word at the 32-bit bus width, so both halves of every word are checked.

// File: rtl/ac_chan_pkg.sv
package ac_chan_pkg;
  localparam int unsigned BANK_SHIFT = 5;

  localparam logic [4:0] OFS_DATA = 5'h00;
  localparam logic [4:0] OFS_RXC  = 5'h04;
  localparam logic [4:0] OFS_TXC  = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_S3  = 3;
  localparam int unsigned CTL_S4  = 4;
  localparam int unsigned CTL_CMP = 15;

  localparam int unsigned ST_TX_EMPTY = 1;
  localparam int unsigned ST_TX_UNDER = 6;

  typedef struct packed {
    logic cmp;
    logic s4;
    logic s3;
    logic en;
  } dir_ctl_t;
endpackage

// File: rtl/ac_chan_fifo.sv
module ac_chan_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [1:0]       push_cnt_i,
  input  logic [W-1:0]     push_d0_i,
  input  logic [W-1:0]     push_d1_i,
  input  logic [1:0]       pop_cnt_i,
  output logic [W-1:0]     head0_o,
  output logic [W-1:0]     head1_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_cnt_i != 2'd0) mem_q[wp_q] <= push_d0_i;
      if (push_cnt_i == 2'd2) mem_q[wp_q + PTR_W'(1)] <= push_d1_i;
      wp_q  <= wp_q + PTR_W'(push_cnt_i);
      rp_q  <= rp_q + PTR_W'(pop_cnt_i);
      cnt_q <= cnt_q + CNT_W'(push_cnt_i) - CNT_W'(pop_cnt_i);
    end
  end

  assign head0_o = mem_q[rp_q];
  assign head1_o = mem_q[rp_q + PTR_W'(1)];
  assign count_o = cnt_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(push_cnt_i) + 32'(count_o)) <= DEPTH);
  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(pop_cnt_i) <= 32'(count_o));
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0));
endmodule

// File: rtl/ac_chan_tx.sv
module ac_chan_tx
  import ac_chan_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SW    = 16,
  localparam int unsigned DW    = 2 * SW,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  dir_ctl_t      ctl_i,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          frame_req_i,
  output logic [1:0]    slot_vld_o,
  output logic [SW-1:0] slot3_o,
  output logic [SW-1:0] slot4_o,
  output logic          empty_o,
  output logic          under_o
);
  logic [DW-1:0]    head0, head1, push_word;
  logic [CNT_W-1:0] count;
  logic [1:0]       need, push_cnt, pop_cnt;
  logic             full, take, avail, under_q;
  logic [SW-1:0]    d3, d4;

  assign full      = count == CNT_W'(DEPTH);
  assign push_word = ctl_i.cmp ? wdata_i : {{SW{1'b0}}, wdata_i[SW-1:0]};
  assign push_cnt  = (wr_i && ctl_i.en && !full && !flush_i) ? 2'd1 : 2'd0;

  always_comb begin
    if (!ctl_i.en)      need = 2'd0;
    else if (ctl_i.cmp) need = {1'b0, ctl_i.s3 | ctl_i.s4};
    else                need = {1'b0, ctl_i.s3} + {1'b0, ctl_i.s4};
  end

  assign take    = frame_req_i && (need != 2'd0);
  assign avail   = count >= CNT_W'(need);
  assign pop_cnt = (take && avail && !flush_i) ? need : 2'd0;

  always_comb begin
    d3 = '0;
    d4 = '0;
    if (take && avail) begin
      if (ctl_i.cmp) begin
        if (ctl_i.s3) d3 = head0[SW-1:0];
        if (ctl_i.s4) d4 = head0[DW-1:SW];
      end else if (ctl_i.s3) begin
        d3 = head0[SW-1:0];
        if (ctl_i.s4) d4 = head1[SW-1:0];
      end else begin
        d4 = head0[SW-1:0];
      end
    end
  end

  ac_chan_fifo #(.DEPTH(DEPTH), .W(DW)) fifo_i (
    .clk_i, .rst_ni, .flush_i,
    .push_cnt_i(push_cnt), .push_d0_i(push_word), .push_d1_i('0),
    .pop_cnt_i(pop_cnt), .head0_o(head0), .head1_o(head1), .count_o(count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      under_q    <= 1'b0;
      slot_vld_o <= '0;
      slot3_o    <= '0;
      slot4_o    <= '0;
    end else begin
      if (flush_i)               under_q <= 1'b0;
      else if (take && !avail)   under_q <= 1'b1;
      slot_vld_o <= take ? {ctl_i.s4, ctl_i.s3} : 2'b00;
      if (frame_req_i) begin
        slot3_o <= d3;
        slot4_o <= d4;
      end
    end
  end

  assign empty_o = count == '0;
  assign under_o = under_q;

  // R6
  under_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(under_q) |-> $past(frame_req_i));
  // R12
  off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_req_i && !ctl_i.en) |=> (slot_vld_o == 2'b00));
endmodule

// File: rtl/ac_chan_rx.sv
module ac_chan_rx
  import ac_chan_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SW    = 16,
  localparam int unsigned DW    = 2 * SW,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  dir_ctl_t      ctl_i,
  input  logic          flush_i,
  input  logic          frame_vld_i,
  input  logic [SW-1:0] slot3_i,
  input  logic [SW-1:0] slot4_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0]    head0, head1, d0, d1;
  logic [CNT_W-1:0] count, room;
  logic [1:0]       n, push_cnt, pop_cnt;

  always_comb begin
    if (!ctl_i.en)      n = 2'd0;
    else if (ctl_i.cmp) n = {1'b0, ctl_i.s3 | ctl_i.s4};
    else                n = {1'b0, ctl_i.s3} + {1'b0, ctl_i.s4};
  end

  assign room     = CNT_W'(DEPTH) - count;
  assign push_cnt = (frame_vld_i && !flush_i && room >= CNT_W'(n)) ? n : 2'd0;
  assign pop_cnt  = (rd_i && count != '0 && !flush_i) ? 2'd1 : 2'd0;

  always_comb begin
    if (ctl_i.cmp)
      d0 = {ctl_i.s4 ? slot4_i : {SW{1'b0}}, ctl_i.s3 ? slot3_i : {SW{1'b0}}};
    else
      d0 = {{SW{1'b0}}, ctl_i.s3 ? slot3_i : slot4_i};
    d1 = {{SW{1'b0}}, slot4_i};
  end

  ac_chan_fifo #(.DEPTH(DEPTH), .W(DW)) fifo_i (
    .clk_i, .rst_ni, .flush_i,
    .push_cnt_i(push_cnt), .push_d0_i(d0), .push_d1_i(d1),
    .pop_cnt_i(pop_cnt), .head0_o(head0), .head1_o(head1), .count_o(count)
  );

  assign rdata_o = (count != '0) ? head0 : '0;

  // R11
  whole_or_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && ctl_i.en && !flush_i && room < CNT_W'(n)) |=> $stable(count) || $past(rd_i));
endmodule

// File: rtl/ac_chan_ctl.sv
module ac_chan_ctl
  import ac_chan_pkg::*;
#(
  parameter int unsigned CHAN_IDX   = 1,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned ADDR_W     = 8,
  localparam int unsigned DW     = 2 * SAMPLE_W,
  localparam int unsigned BANK_W = ADDR_W - BANK_SHIFT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DW-1:0]       bus_wdata_i,
  output logic [DW-1:0]       bus_rdata_o,
  input  logic                tx_frame_req_i,
  output logic [1:0]          tx_slot_vld_o,
  output logic [SAMPLE_W-1:0] tx_slot3_o,
  output logic [SAMPLE_W-1:0] tx_slot4_o,
  input  logic                rx_frame_vld_i,
  input  logic [SAMPLE_W-1:0] rx_slot3_i,
  input  logic [SAMPLE_W-1:0] rx_slot4_i
);
  dir_ctl_t      txc_q, rxc_q, wr_ctl;
  logic          sel, wr_txc, wr_rxc, wr_data, rd_data;
  logic [4:0]    ofs;
  logic          tx_empty, tx_under;
  logic [DW-1:0] rx_word, txc_word, rxc_word, stat_word;

  assign ofs = bus_addr_i[BANK_SHIFT-1:0];
  assign sel = bus_req_i && (bus_addr_i[ADDR_W-1:BANK_SHIFT] == BANK_W'(CHAN_IDX - 1));

  assign wr_txc  = sel &&  bus_we_i && ofs == OFS_TXC;
  assign wr_rxc  = sel &&  bus_we_i && ofs == OFS_RXC;
  assign wr_data = sel &&  bus_we_i && ofs == OFS_DATA;
  assign rd_data = sel && !bus_we_i && ofs == OFS_DATA;

  assign wr_ctl = '{cmp: bus_wdata_i[CTL_CMP], s4: bus_wdata_i[CTL_S4],
                    s3: bus_wdata_i[CTL_S3], en: bus_wdata_i[CTL_EN]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txc_q <= '0;
      rxc_q <= '0;
    end else begin
      if (wr_txc) txc_q <= wr_ctl;
      if (wr_rxc) rxc_q <= wr_ctl;
    end
  end

  ac_chan_tx #(.DEPTH(FIFO_DEPTH), .SW(SAMPLE_W)) tx_i (
    .clk_i, .rst_ni, .ctl_i(txc_q), .flush_i(wr_txc && !bus_wdata_i[CTL_EN]),
    .wr_i(wr_data), .wdata_i(bus_wdata_i), .frame_req_i(tx_frame_req_i),
    .slot_vld_o(tx_slot_vld_o), .slot3_o(tx_slot3_o), .slot4_o(tx_slot4_o),
    .empty_o(tx_empty), .under_o(tx_under)
  );

  ac_chan_rx #(.DEPTH(FIFO_DEPTH), .SW(SAMPLE_W)) rx_i (
    .clk_i, .rst_ni, .ctl_i(rxc_q), .flush_i(wr_rxc && !bus_wdata_i[CTL_EN]),
    .frame_vld_i(rx_frame_vld_i), .slot3_i(rx_slot3_i), .slot4_i(rx_slot4_i),
    .rd_i(rd_data), .rdata_o(rx_word)
  );

  always_comb begin
    txc_word = '0;
    txc_word[CTL_EN] = txc_q.en;  txc_word[CTL_S3]  = txc_q.s3;
    txc_word[CTL_S4] = txc_q.s4;  txc_word[CTL_CMP] = txc_q.cmp;
    rxc_word = '0;
    rxc_word[CTL_EN] = rxc_q.en;  rxc_word[CTL_S3]  = rxc_q.s3;
    rxc_word[CTL_S4] = rxc_q.s4;  rxc_word[CTL_CMP] = rxc_q.cmp;
    stat_word = '0;
    stat_word[ST_TX_EMPTY] = tx_empty;
    stat_word[ST_TX_UNDER] = tx_under;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel && !bus_we_i) begin
      unique case (ofs)
        OFS_DATA: bus_rdata_o = rx_word;
        OFS_RXC:  bus_rdata_o = rxc_word;
        OFS_TXC:  bus_rdata_o = txc_word;
        OFS_STAT: bus_rdata_o = stat_word;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  // R8
  tx_off_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txc && !bus_wdata_i[CTL_EN]) |=> (tx_empty && !tx_under));
endmodule

// File: tb/ac_chan_ctl_tb_top.sv
module ac_chan_ctl_tb_top;
  localparam logic [7:0] BASE = 8'h20;
  localparam logic [7:0] A_DATA = BASE + 8'h00;
  localparam logic [7:0] A_RXC  = BASE + 8'h04;
  localparam logic [7:0] A_TXC  = BASE + 8'h08;
  localparam logic [7:0] A_STAT = BASE + 8'h0C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_req = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_req = 0, rx_vld = 0;
  logic [1:0]  tx_vld;
  logic [15:0] tx_s3, tx_s4, rx_s3 = '0, rx_s4 = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];
  logic        req_seen = 0;

  always #10 clk = ~clk;

  ac_chan_ctl #(.CHAN_IDX(2), .FIFO_DEPTH(8), .SAMPLE_W(16), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_frame_req_i(tx_req), .tx_slot_vld_o(tx_vld), .tx_slot3_o(tx_s3),
    .tx_slot4_o(tx_s4), .rx_frame_vld_i(rx_vld), .rx_slot3_i(rx_s3), .rx_slot4_i(rx_s4)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1;
    check(bus_rdata === exp, tag, 64'(bus_rdata), 64'(exp));
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  // driver: issues a frame request and queues the expected slot contents
  task automatic frame(input logic [1:0] v, input logic [15:0] e3, input logic [15:0] e4, input string tag);
    @(negedge clk);
    tx_req = 1;
    exp_q.push_back({v, e3, e4});
    tag_q.push_back(tag);
    @(negedge clk);
    tx_req = 0;
  endtask

  task automatic rx_frame(input logic [15:0] s3, input logic [15:0] s4);
    @(negedge clk);
    rx_vld = 1; rx_s3 = s3; rx_s4 = s4;
    @(negedge clk);
    rx_vld = 0;
  endtask

  always @(posedge clk) req_seen <= tx_req;

  // monitor: compares slot outputs after each request
  always @(negedge clk) begin
    if (req_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R4: actual unexpected frame expected none");
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({tx_vld, tx_s3, tx_s4} === e, t, 64'({tx_vld, tx_s3, tx_s4}), 64'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(tx_vld === 2'b00, "R1 vld", 64'(tx_vld), 0);
    rd(A_STAT, 32'h2, "R1 status");
    rd(A_TXC, 32'h0, "R1 txc");
    rd(A_RXC, 32'h0, "R1 rxc");
    // R3 field readback
    wr(A_TXC, 32'hFFFF_FFFF);
    rd(A_TXC, 32'h0000_8019, "R3 txc fields");
    wr(A_RXC, 32'hFFFF_FFFF);
    rd(A_RXC, 32'h0000_8019, "R3 rxc fields");
    wr(A_RXC, 0);
    wr(A_TXC, 0);
    // R2 decode: neighbour bank and unmapped offsets
    wr(8'h08, 32'h8019);
    rd(A_TXC, 32'h0, "R2 other bank write ignored");
    rd(8'h08, 32'h0, "R2 other bank read");
    rd(BASE + 8'h10, 32'h0, "R2 unmapped offset");
    // R12 disabled transmit
    frame(2'b00, 16'h0, 16'h0, "R12 off frame");
    rd(A_STAT, 32'h2, "R12 no underrun");
    // R4 compact
    wr(A_TXC, 32'h8019);
    wr(A_DATA, 32'hBBBB_AAAA);
    wr(A_DATA, 32'h2222_1111);
    rd(A_STAT, 32'h0, "R7 not empty");
    frame(2'b11, 16'hAAAA, 16'hBBBB, "R4 compact 1");
    frame(2'b11, 16'h1111, 16'h2222, "R4 compact 2");
    rd(A_STAT, 32'h2, "R7 empty after drain");
    // R6 underrun
    frame(2'b11, 16'h0, 16'h0, "R6 underrun zeros");
    rd(A_STAT, 32'h42, "R6 underrun flag");
    wr(A_DATA, 32'h4444_3333);
    frame(2'b11, 16'h3333, 16'h4444, "R6 resume");
    rd(A_STAT, 32'h42, "R6 flag sticky");
    // R8 disable clears and drops writes
    wr(A_TXC, 32'h0);
    rd(A_STAT, 32'h2, "R8 disable clears");
    wr(A_DATA, 32'h5555_5555);
    wr(A_TXC, 32'h8019);
    frame(2'b11, 16'h0, 16'h0, "R8 write while off dropped");
    wr(A_TXC, 32'h0);
    // R4 compact slot 4 only
    wr(A_TXC, 32'h8011);
    wr(A_DATA, 32'h6666_7777);
    frame(2'b10, 16'h0, 16'h6666, "R4 slot4 only");
    wr(A_TXC, 32'h0);
    // R5 one-sample mode
    wr(A_TXC, 32'h19);
    wr(A_DATA, 32'hFFFF_1234);
    wr(A_DATA, 32'h0000_5678);
    frame(2'b11, 16'h1234, 16'h5678, "R5 two slots");
    wr(A_DATA, 32'h0000_9ABC);
    frame(2'b11, 16'h0, 16'h0, "R6 short for two slots");
    rd(A_STAT, 32'h40, "R6 kept entry");
    wr(A_TXC, 32'h0);
    wr(A_TXC, 32'h09);
    wr(A_DATA, 32'h00AA);
    wr(A_DATA, 32'h00BB);
    frame(2'b01, 16'h00AA, 16'h0, "R5 slot3 a");
    frame(2'b01, 16'h00BB, 16'h0, "R5 slot3 b");
    wr(A_TXC, 32'h0);
    // R9 depth
    wr(A_TXC, 32'h8019);
    for (int k = 1; k <= 9; k++) wr(A_DATA, 32'(k) * 32'h0001_0001);
    for (int k = 1; k <= 8; k++) frame(2'b11, 16'(k), 16'(k), "R9 fifo order");
    frame(2'b11, 16'h0, 16'h0, "R9 ninth dropped");
    wr(A_TXC, 32'h0);
    // R10 receive compact
    wr(A_RXC, 32'h8019);
    rx_frame(16'h1111, 16'h2222);
    rd(A_DATA, 32'h2222_1111, "R10 compact entry");
    rd(A_DATA, 32'h0, "R10 empty read");
    wr(A_RXC, 32'h8009);
    rx_frame(16'h3333, 16'h4444);
    rd(A_DATA, 32'h0000_3333, "R10 slot4 masked");
    // R8 receive flush
    rx_frame(16'h7777, 16'h8888);
    wr(A_RXC, 32'h0);
    wr(A_RXC, 32'h19);
    rd(A_DATA, 32'h0, "R8 rx flushed");
    // R11 one-sample receive, whole-frame drop
    for (int k = 0; k < 3; k++) rx_frame(16'h0A00 + 16'(k), 16'h0B00 + 16'(k));
    wr(A_RXC, 32'h09);
    rx_frame(16'h0C00, 16'h0D00);
    wr(A_RXC, 32'h19);
    rx_frame(16'h0E00, 16'h0F00);
    for (int k = 0; k < 3; k++) begin
      rd(A_DATA, 32'h0A00 + 32'(k), "R11 slot3 order");
      rd(A_DATA, 32'h0B00 + 32'(k), "R11 slot4 order");
    end
    rd(A_DATA, 32'h0C00, "R11 single entry");
    rd(A_DATA, 32'h0, "R11 partial frame dropped");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all frames seen", 64'(exp_q.size()), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule